// File: doc/BRIEF.md
# Fault-Tagged Instruction Prefetch Queue

This block sits between an instruction fetch bus and a decode stage. It requests 16-bit instruction words at consecutive even addresses, holds them in a small circular queue and hands them to decode in order. A bus error on a fetch does not interrupt anything when the response arrives. The error becomes a one-bit fault mark stored next to the word. The fault is raised only if decode actually takes that word. Words that are thrown away before decode uses them take their fault marks with them.

A change of flow is a redirect. It empties the queue and moves the fetch pointer to a new target. A target with an odd address starts no fetch and raises an address error instead. Each bus request carries an epoch tag. A response whose tag belongs to an earlier epoch is dropped, so words fetched before a redirect can never enter the queue after it.

When decode takes a word that carries a fault mark, the block asserts `kill` in the same cycle, so that the instruction leaves no architectural update. One cycle later it pulses an access-error exception. After any exception the queue stays empty and fetching stops until the next redirect.

Top module: `ftag_prefetch_q`

## Requirements
- R1: After reset, no fetch is requested, `dec_valid` is 0 and no exception or kill is signalled until the first redirect.
- R2: After an aligned redirect, fetches are requested at the target address and then at each following even address (step 2). `fetch_req` is high exactly when the block is not halted, no redirect is present, and stored words plus outstanding current-epoch requests are fewer than DEPTH.
- R3: `dec_valid` is high exactly when the queue holds a word. `dec_word` presents the oldest stored word. Words are delivered in fetch order.
- R4: A response with `fetch_rsp_err` set raises no exception when it arrives. No exception occurs in any cycle unless R5 or R9 calls for it.
- R5: When decode pops (`dec_pop` with `dec_valid`, and no redirect) a word stored with its fault mark set, `kill` is high in that cycle. In the next cycle `exc_valid` pulses with `exc_code` = 1 (access error).
- R6: After an exception, `dec_valid` and `fetch_req` stay 0 until the next redirect, and responses are not stored.
- R7: A redirect discards all stored words, including words that carry fault marks. Those words never raise an exception.
- R8: A response whose `fetch_rsp_tag` differs from the tag of the current epoch is dropped. The epoch advances on every redirect and on every access error.
- R9: A redirect whose target has bit 0 set requests no fetch. In the next cycle `exc_valid` pulses with `exc_code` = 2 (address error).
- R10: When a redirect and a pop fall in the same cycle, the redirect wins. The popped word is discarded without kill or exception, even if it carries a fault mark.
- R11: `exc_valid` lasts one cycle unless a new odd redirect arrives during the pulse. `exc_code` is 0 whenever no exception is signalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_req | output | 1 | Fetch request, taken by the bus in the same cycle |
| fetch_addr | output | AW | Byte address of the requested word |
| fetch_tag | output | EPOCH_W | Epoch tag attached to the request |
| fetch_rsp_valid | input | 1 | Fetch response present |
| fetch_rsp_data | input | 16 | Returned instruction word |
| fetch_rsp_err | input | 1 | Bus error on this response |
| fetch_rsp_tag | input | EPOCH_W | Tag echoed from the request |
| redir_valid | input | 1 | Change-of-flow redirect |
| redir_target | input | AW | Redirect target byte address |
| dec_pop | input | 1 | Decode takes the presented word |
| dec_valid | output | 1 | A word is presented to decode |
| dec_word | output | 16 | Presented instruction word |
| kill | output | 1 | Abort of the instruction that consumed a faulted word |
| exc_valid | output | 1 | Exception pulse |
| exc_code | output | 2 | 0 none, 1 access error, 2 address error |

## Verification
Two collisions matter here: a redirect and a decode pop can land in the same cycle, and a stale response can arrive in the cycle of a redirect or just after it. Directed steps build a queue whose head carries a fault mark and then assert the redirect and the pop together. Random stimulus adds frequent pops, occasional redirects and bus latencies of up to four cycles, so these collisions also occur without being set up. A reference queue in the bench, keyed by epoch generation, is the judge. It predicts kill as 0 and no exception for the collided pop, and it expects the first word after the redirect to be the one at the new target.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

   localparam int unsigned WORD_W = 16;

   typedef enum logic [1:0] {
      EXC_NONE   = 2'd0,
      EXC_ACCESS = 2'd1,
      EXC_ADDR   = 2'd2
   } exc_code_e;

   typedef struct packed {
      logic              fault;
      logic [WORD_W-1:0] word;
   } slot_t;

endpackage

// File: rtl/pfq_store.sv
module pfq_store
   import pfq_pkg::*;
#(
   parameter int unsigned DEPTH = 4,
   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push,
   input  slot_t            push_slot,
   input  logic             pop,
   output slot_t            head,
   output logic [CNT_W-1:0] count
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("pfq_store: DEPTH must be at least 2");
   end

   logic [PTR_W-1:0] rd_ptr_q;
   logic [PTR_W-1:0] wr_ptr_q;
   logic [CNT_W-1:0] cnt_q;
   slot_t            slot_view [DEPTH];

   function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
   endfunction

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      slot_t slot_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            slot_q <= '0;
         end else if (push && !flush && (wr_ptr_q == PTR_W'(i))) begin
            slot_q <= push_slot;
         end
      end
      assign slot_view[i] = slot_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr_q <= '0;
         wr_ptr_q <= '0;
         cnt_q    <= '0;
      end else if (flush) begin
         rd_ptr_q <= '0;
         wr_ptr_q <= '0;
         cnt_q    <= '0;
      end else begin
         if (push) wr_ptr_q <= ptr_next(wr_ptr_q);
         if (pop)  rd_ptr_q <= ptr_next(rd_ptr_q);
         cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop);
      end
   end

   assign head  = slot_view[rd_ptr_q];
   assign count = cnt_q;

endmodule

// File: rtl/pfq_fetch_ctl.sv
module pfq_fetch_ctl #(
   parameter int unsigned AW      = 24,
   parameter int unsigned DEPTH   = 4,
   parameter int unsigned EPOCH_W = 3,
   localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               flush,
   input  logic               restart,
   input  logic [AW-1:0]      restart_addr,
   input  logic               halted,
   input  logic               hold,
   input  logic [CNT_W-1:0]   occupancy,
   input  logic               rsp_valid,
   input  logic [EPOCH_W-1:0] rsp_tag,
   output logic               req,
   output logic [AW-1:0]      req_addr,
   output logic [EPOCH_W-1:0] req_tag,
   output logic               accept
);

   if (EPOCH_W < 1) begin : g_bad_epoch
      $error("pfq_fetch_ctl: EPOCH_W must be at least 1");
   end
   if (AW < 2) begin : g_bad_aw
      $error("pfq_fetch_ctl: AW must be at least 2");
   end

   logic [AW-1:0]      pc_q;
   logic [EPOCH_W-1:0] epoch_q;
   logic [CNT_W-1:0]   inflight_q;
   logic [CNT_W:0]     load;

   assign load     = {1'b0, occupancy} + {1'b0, inflight_q};
   assign req      = !halted && !hold && (load < (CNT_W + 1)'(DEPTH));
   assign req_addr = pc_q;
   assign req_tag  = epoch_q;
   assign accept   = rsp_valid && (rsp_tag == epoch_q) && !halted && !flush;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q       <= '0;
         epoch_q    <= '0;
         inflight_q <= '0;
      end else begin
         if (restart)  pc_q <= restart_addr;
         else if (req) pc_q <= pc_q + AW'(2);

         if (flush) begin
            epoch_q    <= epoch_q + EPOCH_W'(1);
            inflight_q <= '0;
         end else begin
            inflight_q <= inflight_q + CNT_W'(req) - CNT_W'(accept);
         end
      end
   end

endmodule

// File: rtl/pfq_fault_ctl.sv
module pfq_fault_ctl
   import pfq_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      redir_valid,
   input  logic      redir_odd,
   input  logic      consume,
   input  logic      head_fault,
   output logic      halted,
   output logic      kill,
   output logic      flush,
   output logic      exc_valid,
   output exc_code_e exc_code
);

   logic      halted_q;
   logic      exc_valid_q;
   exc_code_e exc_code_q;

   assign kill  = consume && head_fault && !redir_valid;
   assign flush = redir_valid || kill;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halted_q    <= 1'b1;
         exc_valid_q <= 1'b0;
         exc_code_q  <= EXC_NONE;
      end else if (redir_valid) begin
         halted_q    <= redir_odd;
         exc_valid_q <= redir_odd;
         exc_code_q  <= redir_odd ? EXC_ADDR : EXC_NONE;
      end else if (kill) begin
         halted_q    <= 1'b1;
         exc_valid_q <= 1'b1;
         exc_code_q  <= EXC_ACCESS;
      end else begin
         exc_valid_q <= 1'b0;
         exc_code_q  <= EXC_NONE;
      end
   end

   assign halted    = halted_q;
   assign exc_valid = exc_valid_q;
   assign exc_code  = exc_code_q;

endmodule

// File: rtl/ftag_prefetch_q.sv
module ftag_prefetch_q
   import pfq_pkg::*;
#(
   parameter int unsigned AW      = 24,
   parameter int unsigned DEPTH   = 4,
   parameter int unsigned EPOCH_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   output logic               fetch_req,
   output logic [AW-1:0]      fetch_addr,
   output logic [EPOCH_W-1:0] fetch_tag,
   input  logic               fetch_rsp_valid,
   input  logic [15:0]        fetch_rsp_data,
   input  logic               fetch_rsp_err,
   input  logic [EPOCH_W-1:0] fetch_rsp_tag,
   input  logic               redir_valid,
   input  logic [AW-1:0]      redir_target,
   input  logic               dec_pop,
   output logic               dec_valid,
   output logic [15:0]        dec_word,
   output logic               kill,
   output logic               exc_valid,
   output logic [1:0]         exc_code
);

   localparam int unsigned CNT_W = $clog2(DEPTH + 1);

   if (WORD_W != 16) begin : g_bad_word
      $error("ftag_prefetch_q: word width must be 16");
   end

   logic             halted;
   logic             flush;
   logic             consume;
   logic             accept;
   logic             kill_i;
   logic [CNT_W-1:0] count;
   slot_t            head;
   slot_t            push_slot;
   exc_code_e        exc_code_i;

   assign dec_valid = (count != '0) && !halted;
   assign dec_word  = head.word;
   assign consume   = dec_pop && dec_valid;
   assign push_slot = '{fault: fetch_rsp_err, word: fetch_rsp_data};
   assign kill      = kill_i;
   assign exc_code  = exc_code_i;

   pfq_fault_ctl u_fault (
      .clk         (clk),
      .rst_n       (rst_n),
      .redir_valid (redir_valid),
      .redir_odd   (redir_target[0]),
      .consume     (consume),
      .head_fault  (head.fault),
      .halted      (halted),
      .kill        (kill_i),
      .flush       (flush),
      .exc_valid   (exc_valid),
      .exc_code    (exc_code_i)
   );

   pfq_fetch_ctl #(.AW(AW), .DEPTH(DEPTH), .EPOCH_W(EPOCH_W)) u_fetch (
      .clk          (clk),
      .rst_n        (rst_n),
      .flush        (flush),
      .restart      (redir_valid && !redir_target[0]),
      .restart_addr (redir_target),
      .halted       (halted),
      .hold         (redir_valid),
      .occupancy    (count),
      .rsp_valid    (fetch_rsp_valid),
      .rsp_tag      (fetch_rsp_tag),
      .req          (fetch_req),
      .req_addr     (fetch_addr),
      .req_tag      (fetch_tag),
      .accept       (accept)
   );

   pfq_store #(.DEPTH(DEPTH)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush),
      .push      (accept),
      .push_slot (push_slot),
      .pop       (consume && !flush),
      .head      (head),
      .count     (count)
   );

endmodule

// File: rtl/pfq_checker.sv
module pfq_checker #(
   parameter int unsigned AW = 24
) (
   input logic          clk,
   input logic          rst_n,
   input logic          fetch_req,
   input logic [AW-1:0] fetch_addr,
   input logic          redir_valid,
   input logic [AW-1:0] redir_target,
   input logic          dec_valid,
   input logic          kill,
   input logic          exc_valid,
   input logic [1:0]    exc_code
);

   AST_KILL_THEN_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      kill |=> (exc_valid && exc_code == 2'd1)); // R5

   AST_ODD_TARGET_ADDR_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (redir_valid && redir_target[0]) |=> (exc_valid && exc_code == 2'd2)); // R9

   AST_QUIET_AFTER_EXC: assert property (@(posedge clk) disable iff (!rst_n)
      exc_valid |-> (!fetch_req && !dec_valid)); // R6

   AST_REDIR_BEATS_POP: assert property (@(posedge clk) disable iff (!rst_n)
      redir_valid |-> !kill); // R10

   AST_EXC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_valid && !redir_valid) |=> !exc_valid); // R11

   AST_NO_CODE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !exc_valid |-> (exc_code == 2'd0)); // R11

   AST_FETCH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_req && $past(fetch_req)) |-> (fetch_addr == $past(fetch_addr) + AW'(2))); // R2

   AST_FETCH_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_req |-> !fetch_addr[0]); // R2

endmodule

bind ftag_prefetch_q pfq_checker #(.AW(AW)) u_pfq_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .fetch_req    (fetch_req),
   .fetch_addr   (fetch_addr),
   .redir_valid  (redir_valid),
   .redir_target (redir_target),
   .dec_valid    (dec_valid),
   .kill         (kill),
   .exc_valid    (exc_valid),
   .exc_code     (exc_code)
);

// File: tb/test_ftag_prefetch_q.sv
module test_ftag_prefetch_q;

   localparam int CLK_PERIOD = 10;
   localparam int AW         = 24;
   localparam int DEPTH      = 4;
   localparam int EW         = 3;
   localparam int MAX_CYC    = 150000;

   typedef struct {
      logic [AW-1:0] addr;
      logic [EW-1:0] tag;
      int            gen;
      bit            err;
      int            due;
   } bus_rec_t;

   typedef struct {
      logic [15:0] data;
      bit          err;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          fetch_req;
   logic [AW-1:0] fetch_addr;
   logic [EW-1:0] fetch_tag;
   logic          fetch_rsp_valid = 1'b0;
   logic [15:0]   fetch_rsp_data = '0;
   logic          fetch_rsp_err = 1'b0;
   logic [EW-1:0] fetch_rsp_tag = '0;
   logic          redir_valid = 1'b0;
   logic [AW-1:0] redir_target = '0;
   logic          dec_pop = 1'b0;
   logic          dec_valid;
   logic [15:0]   dec_word;
   logic          kill;
   logic          exc_valid;
   logic [1:0]    exc_code;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;
   int kills_seen = 0;
   int addr_errs_seen = 0;
   bit done = 0;

   bus_rec_t      bus_q[$];
   exp_t          exp_q[$];
   int            gen = 0;
   int            infl = 0;
   bit            exp_halted = 1;
   bit            seen_redir = 0;
   int            exp_exc = 0;
   logic [AW-1:0] exp_fpc = '0;
   int            last_flush = -10;
   logic [AW-1:0] force_addr = '1;
   int            err_pct = 0;
   int            lat_max = 1;

   always #(CLK_PERIOD / 2) clk = ~clk;

   ftag_prefetch_q #(.AW(AW), .DEPTH(DEPTH), .EPOCH_W(EW)) i_ftag_prefetch_q (
      .clk             (clk),
      .rst_n           (rst_n),
      .fetch_req       (fetch_req),
      .fetch_addr      (fetch_addr),
      .fetch_tag       (fetch_tag),
      .fetch_rsp_valid (fetch_rsp_valid),
      .fetch_rsp_data  (fetch_rsp_data),
      .fetch_rsp_err   (fetch_rsp_err),
      .fetch_rsp_tag   (fetch_rsp_tag),
      .redir_valid     (redir_valid),
      .redir_target    (redir_target),
      .dec_pop         (dec_pop),
      .dec_valid       (dec_valid),
      .dec_word        (dec_word),
      .kill            (kill),
      .exc_valid       (exc_valid),
      .exc_code        (exc_code)
   );

   function automatic logic [15:0] data_of(input logic [AW-1:0] a);
      return a[16:1] ^ 16'h5A3C;
   endfunction

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s cycle %0d: actual=%0h expected=%0h", req, cyc, act, exp);
      end
   endtask

   task automatic step(input bit rv, input logic [AW-1:0] tgt, input bit pop);
      bit   rsp_taken;
      bit   exp_req, exp_dv, exp_kill, s_req;
      logic [AW-1:0] s_addr;
      logic [EW-1:0] s_tag;
      bus_rec_t rec;
      @(negedge clk);
      redir_valid  = rv;
      redir_target = tgt;
      dec_pop      = pop;
      rsp_taken    = 0;
      fetch_rsp_valid = 1'b0;
      if (bus_q.size() > 0 && bus_q[0].due <= cyc && ($urandom_range(3) != 0 || lat_max == 1)) begin
         rsp_taken       = 1;
         fetch_rsp_valid = 1'b1;
         fetch_rsp_data  = data_of(bus_q[0].addr);
         fetch_rsp_err   = bus_q[0].err;
         fetch_rsp_tag   = bus_q[0].tag;
      end
      #1;
      // exception output from the previous cycle
      if (exp_exc == 1)      chk(exc_valid && exc_code == 2'd1, "R5", {exc_valid, exc_code}, 4'h5);
      else if (exp_exc == 2) chk(exc_valid && exc_code == 2'd2, "R9", {exc_valid, exc_code}, 4'h6);
      else                   chk(!exc_valid && exc_code == 2'd0, "R4,R7,R11", {exc_valid, exc_code}, 0);
      exp_req = !exp_halted && !rv && ((exp_q.size() + infl) < DEPTH);
      if (!seen_redir)     chk(fetch_req == exp_req, "R1", fetch_req, exp_req);
      else if (exp_halted) chk(fetch_req == exp_req, "R6", fetch_req, exp_req);
      else                 chk(fetch_req == exp_req, "R2", fetch_req, exp_req);
      if (fetch_req && exp_req) chk(fetch_addr == exp_fpc, "R2", fetch_addr, exp_fpc);
      exp_dv = !exp_halted && exp_q.size() > 0;
      chk(dec_valid == exp_dv, exp_halted ? "R6" : "R3", dec_valid, exp_dv);
      if (dec_valid && exp_dv) chk(dec_word == exp_q[0].data, "R3,R8", dec_word, exp_q[0].data);
      exp_kill = pop && exp_dv && !rv && exp_q[0].err;
      chk(kill == exp_kill, exp_kill ? "R5" : (rv ? "R10" : "R4"), kill, exp_kill);
      s_req  = fetch_req;
      s_addr = fetch_addr;
      s_tag  = fetch_tag;
      @(posedge clk);
      cyc++;
      if (rsp_taken) begin
         rec = bus_q.pop_front();
         if (rec.gen == gen && !exp_halted && !rv && !exp_kill) begin
            exp_q.push_back('{data: data_of(rec.addr), err: rec.err});
            infl--;
         end
      end
      if (s_req) begin
         rec.addr = s_addr;
         rec.tag  = s_tag;
         rec.gen  = gen;
         rec.err  = (s_addr == force_addr) || ($urandom_range(99) < err_pct);
         rec.due  = cyc + $urandom_range(lat_max - 1);
         bus_q.push_back(rec);
         exp_fpc += AW'(2);
         infl++;
      end
      if (rv) begin
         exp_q.delete();
         infl = 0;
         gen++;
         exp_halted = tgt[0];
         exp_exc    = tgt[0] ? 2 : 0;
         if (tgt[0]) addr_errs_seen++;
         exp_fpc    = tgt;
         seen_redir = 1;
         last_flush = cyc;
      end else if (exp_kill) begin
         exp_q.delete();
         infl = 0;
         gen++;
         exp_halted = 1;
         exp_exc    = 1;
         kills_seen++;
         last_flush = cyc;
      end else begin
         exp_exc = 0;
         if (pop && exp_dv) void'(exp_q.pop_front());
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(0, '0, 0);
   endtask

   initial begin
      void'($urandom(32'd4021));
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      chk(fetch_req == 0, "R1", fetch_req, 0);
      chk(dec_valid == 0, "R1", dec_valid, 0);
      chk(exc_valid == 0 && kill == 0, "R1", {exc_valid, kill}, 0);
      @(negedge clk);
      rst_n = 1'b1;
      idle(4);                                     // R1: still idle

      step(1, 24'h000101, 0);                      // R9: odd target
      idle(3);

      force_addr = 24'h000204;                     // R5: faulted word consumed
      step(1, 24'h000200, 0);
      idle(8);
      step(0, '0, 1); step(0, '0, 1); step(0, '0, 1);
      idle(4);                                     // R6: quiet after access error

      force_addr = 24'h000300;                     // R10: redirect with pop of faulted head
      step(1, 24'h000300, 0);
      idle(8);
      step(1, 24'h000400, 1);
      force_addr = 24'h000402;                     // R7: faulted word flushed
      idle(8);
      step(0, '0, 1);
      step(1, 24'h000500, 0);
      idle(6);
      step(0, '0, 1); step(0, '0, 1);

      lat_max = 4;                                 // R8: stale responses
      step(1, 24'h000600, 0);
      idle(2);
      step(1, 24'h000700, 0);
      idle(8);
      step(0, '0, 1); step(0, '0, 1);

      force_addr = '1;
      err_pct    = 15;
      for (int i = 0; i < 5000; i++) begin
         bit rv;
         logic [AW-1:0] tgt;
         rv  = (cyc - last_flush >= 2) && ($urandom_range(99) < 6);
         tgt = AW'($urandom_range(32'h7FFF) << 1);
         if ($urandom_range(99) < 15) tgt[0] = 1'b1;
         step(rv, tgt, $urandom_range(99) < 55);
      end
      chk(kills_seen > 2, "R5", kills_seen, 3);
      chk(addr_errs_seen > 2, "R9", addr_errs_seen, 3);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int n;
      n = 0;
      while (n < MAX_CYC && !done) begin
         @(posedge clk);
         n++;
      end
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=%0d expected=%0d", n, 0);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule